// File: doc/BRIEF.md
# Multi-channel PWM with staged edge update

This block is a register-programmed pulse-width generator with up to sixteen channels sharing one period counter. The counter runs from zero up to the period value and then wraps. Each channel has a set-edge position and a clear-edge position. Its output rises when the counter reaches the set position and falls when it reaches the clear position, so one pair of values places the pulse anywhere inside the period, including a pulse that crosses the wrap.

A synthesis mask gives each channel one of two update modes. A direct channel takes an edge write on the next cycle, even if that breaks a pulse already in progress. A staged channel puts the write into a holding copy. Software writes every holding copy it needs, then issues a one-shot commit command. At the first period wrap after the command, all held values move into the live set together. If any channel is staged, the period register is staged in the same way. Readback always returns the live values, so software can poll the command register until it reads zero, and at that point the new settings are in effect.

Register map (6-bit address):

| Address | Register |
|---|---|
| 0x00 | period |
| 0x01 | enables for channels 0-7 |
| 0x02 | enables for channels 8-15 |
| 0x03 | commit command (bit 0) |
| 0x10+2n | set edge of channel n |
| 0x11+2n | clear edge of channel n |

Addresses that are not mapped read as 0.

Top module: `pwm_shadow_top`

## Requirements
- R1: After an active-low reset, the period reads 0xFF (all ones), every edge and enable register reads 0, the commit register at 0x03 reads 0, and every output is 0.
- R2: The counter counts up by one each cycle. On the cycle where the counter is at or above the live period (register 0x00), it returns to 0 on the next cycle. That cycle is the period end.
- R3: The output of channel n goes to 1 on the cycle after the counter equals the live set edge (0x10+2n). It goes to 0 on the cycle after the counter equals the live clear edge (0x11+2n). If the two edges are equal, the output stays 0.
- R4: Channel c is enabled by bit c mod 8 of register 0x01 for c<8, or of register 0x02 for c>=8. The cycle after its enable bit is cleared, a channel outputs 0. Both registers read back their bits.
- R5: On a direct channel, an edge write is live, and visible on readback, from the next cycle.
- R6: On a staged channel, and for the period when any channel is staged, a write changes neither the output nor the readback until a commit.
- R7: Writing 0x03 with bit 0 set makes 0x03 read 1. At the first period end that follows, every held edge value and the held period become live on the same cycle.
- R8: The commit command clears itself on the commit cycle. A held value written after that commit never becomes live unless 0x03 is written with bit 0 set again.
- R9: A write to 0x03 with bit 0 clear has no effect; 0x03 still reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 6 | Register address, shared by read and write |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Combinational readback of the live register at addr_i |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
A counter that is out of step or a wrong wrap compare moves every edge of every channel. The output stream shows this within one period, and the bench compares that stream on every cycle against its own model. A commit request left set, or lost, shows up on the next read of 0x03, or as outputs that change at a period end with no command. If the held and live copies are swapped in readback, the first read after a staged write shows it. A direct channel that was built as staged shows it within one cycle of the edge write.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_PERIOD = 6'h00;
  localparam logic [ADDR_W-1:0] A_EN_LO  = 6'h01;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 6'h02;
  localparam logic [ADDR_W-1:0] A_SYNC   = 6'h03;

  function automatic logic [ADDR_W-1:0] set_addr(input int c);
    return ADDR_W'(16 + 2 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] clr_addr(input int c);
    return ADDR_W'(17 + 2 * c);
  endfunction
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned CNT_W  = 8,
  parameter bit          SHADOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             commit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eop_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] per_stg_o
);
  logic [CNT_W-1:0] cnt_q, per_q;

  assign eop_o = (cnt_q >= per_q);
  assign cnt_o = cnt_q;
  assign per_o = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (eop_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  if (SHADOW) begin : g_shd
    logic [CNT_W-1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q <= '1;
        per_q <= '1;
      end else begin
        if (we_i)     stg_q <= wdata_i;
        if (commit_i) per_q <= stg_q;
      end
    end
    assign per_stg_o = stg_q;
  end else begin : g_dir
    logic unused_commit;
    assign unused_commit = commit_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   per_q <= '1;
      else if (we_i) per_q <= wdata_i;
    end
    assign per_stg_o = per_q;
  end
endmodule

// File: rtl/pwm_edge_regs.sv
module pwm_edge_regs #(
  parameter int unsigned CNT_W  = 8,
  parameter bit          SHADOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_set_i,
  input  logic             we_clr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             commit_i,
  output logic [CNT_W-1:0] set_o,
  output logic [CNT_W-1:0] clr_o
);
  logic [CNT_W-1:0] set_q, clr_q;
  assign set_o = set_q;
  assign clr_o = clr_q;

  if (SHADOW) begin : g_shd
    logic [CNT_W-1:0] set_stg_q, clr_stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        set_stg_q <= '0;
        clr_stg_q <= '0;
        set_q     <= '0;
        clr_q     <= '0;
      end else begin
        if (we_set_i) set_stg_q <= wdata_i;
        if (we_clr_i) clr_stg_q <= wdata_i;
        if (commit_i) begin
          set_q <= set_stg_q;
          clr_q <= clr_stg_q;
        end
      end
    end
  end else begin : g_dir
    logic unused_commit;
    assign unused_commit = commit_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        set_q <= '0;
        clr_q <= '0;
      end else begin
        if (we_set_i) set_q <= wdata_i;
        if (we_clr_i) clr_q <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] set_i,
  input  logic [CNT_W-1:0] clr_i,
  input  logic             en_i,
  output logic             out_o
);
  logic out_q, hit_set, hit_clr;
  assign hit_set = (cnt_i == set_i) && (set_i != clr_i);
  assign hit_clr = (cnt_i == clr_i);
  assign out_o   = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= en_i && (hit_set || (out_q && !hit_clr));
  end
endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned       NUM_CH      = 16,
  parameter int unsigned       CNT_W       = 8,
  parameter logic [NUM_CH-1:0] SHADOW_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam bit PER_SHADOW = |SHADOW_MASK;

  logic [CNT_W-1:0] cnt, per_act, per_stg;
  logic             eop, sync_q, sync_wr, commit;
  logic [NUM_CH-1:0] en_q;
  logic [15:0]       en_full;
  logic [NUM_CH-1:0][CNT_W-1:0] set_act, clr_act;

  assign sync_wr = we_i && (addr_i == A_SYNC) && wdata_i[0];
  assign commit  = sync_q && eop;
  assign en_full = 16'(en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= (sync_q && !eop) || sync_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (we_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr_i == ((c < 8) ? A_EN_LO : A_EN_HI)) en_q[c] <= wdata_i[c % 8];
      end
    end
  end

  pwm_period_ctr #(.CNT_W(CNT_W), .SHADOW(PER_SHADOW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i && (addr_i == A_PERIOD)),
    .wdata_i   (wdata_i),
    .commit_i  (commit),
    .cnt_o     (cnt),
    .eop_o     (eop),
    .per_o     (per_act),
    .per_stg_o (per_stg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_edge_regs #(.CNT_W(CNT_W), .SHADOW(SHADOW_MASK[c])) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_set_i (we_i && (addr_i == set_addr(c))),
      .we_clr_i (we_i && (addr_i == clr_addr(c))),
      .wdata_i  (wdata_i),
      .commit_i (commit),
      .set_o    (set_act[c]),
      .clr_o    (clr_act[c])
    );
    pwm_chan_out #(.CNT_W(CNT_W)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .set_i  (set_act[c]),
      .clr_i  (clr_act[c]),
      .en_i   (en_q[c]),
      .out_o  (pwm_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_PERIOD)     rdata_o = per_act;
    else if (addr_i == A_EN_LO) rdata_o = CNT_W'(en_full[7:0]);
    else if (addr_i == A_EN_HI) rdata_o = CNT_W'(en_full[15:8]);
    else if (addr_i == A_SYNC)  rdata_o = CNT_W'(sync_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == set_addr(c)) rdata_o = set_act[c];
      if (addr_i == clr_addr(c)) rdata_o = clr_act[c];
    end
  end
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
  parameter int unsigned NUM_CH     = 16,
  parameter int unsigned CNT_W      = 8,
  parameter bit          PER_SHADOW = 1'b0
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          we_i,
  input logic [5:0]                    addr_i,
  input logic [CNT_W-1:0]              wdata_i,
  input logic [CNT_W-1:0]              cnt,
  input logic                          eop,
  input logic [CNT_W-1:0]              per_act,
  input logic [CNT_W-1:0]              per_stg,
  input logic                          sync_q,
  input logic [NUM_CH-1:0]             en_q,
  input logic [NUM_CH-1:0][CNT_W-1:0]  set_act,
  input logic [NUM_CH-1:0][CNT_W-1:0]  clr_act,
  input logic [NUM_CH-1:0]             pwm_o
);
  logic sync_wr;
  assign sync_wr = we_i && (addr_i == 6'h03) && wdata_i[0];

  a_r2_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop |=> (cnt == '0));
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eop |=> (cnt == $past(cnt) + 1'b1));
  a_r7_sync_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_wr |=> sync_q);
  a_r8_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && eop && !sync_wr) |=> !sync_q);

  if (PER_SHADOW) begin : g_per
    a_r7_per_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_q && eop) |=> (per_act == $past(per_stg)));
    a_r6_per_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sync_q && eop) |=> $stable(per_act));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r4_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q[c] |=> !pwm_o[c]);
    a_r3_equal_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((set_act[c] == clr_act[c]) && !pwm_o[c]) |=> !pwm_o[c]);
  end
endmodule

bind pwm_shadow_top pwm_shadow_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PER_SHADOW(PER_SHADOW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .cnt     (cnt),
  .eop     (eop),
  .per_act (per_act),
  .per_stg (per_stg),
  .sync_q  (sync_q),
  .en_q    (en_q),
  .set_act (set_act),
  .clr_act (clr_act),
  .pwm_o   (pwm_o)
);

// File: tb/pwm_shadow_top_tb_top.sv
module pwm_shadow_top_tb_top;
  localparam int NCH = 10;
  localparam logic [NCH-1:0] SH = 10'b10_0000_1010;
  localparam bit PER_SH = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] addr = 6'h3f;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NCH-1:0] pwm;

  int n_chk = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_shadow_top #(.NUM_CH(NCH), .CNT_W(8), .SHADOW_MASK(SH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // behavioural model built from the requirements
  logic [7:0] m_cnt, m_per, m_per_s;
  logic       m_pend;
  logic [NCH-1:0] m_en, m_out, m_nx;
  logic [7:0] m_sa [NCH];
  logic [7:0] m_ca [NCH];
  logic [7:0] m_ss [NCH];
  logic [7:0] m_cs [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_per = 8'hff; m_per_s = 8'hff; m_pend = 1'b0;
      m_en = '0; m_out = '0;
      for (int c = 0; c < NCH; c++) begin
        m_sa[c] = '0; m_ca[c] = '0; m_ss[c] = '0; m_cs[c] = '0;
      end
    end else begin
      automatic bit eop = (m_cnt >= m_per);
      for (int c = 0; c < NCH; c++)
        m_nx[c] = m_en[c] && ((m_cnt == m_sa[c] && m_sa[c] != m_ca[c]) ||
                              (m_out[c] && m_cnt != m_ca[c]));
      if (eop && m_pend) begin
        if (PER_SH) m_per = m_per_s;
        for (int c = 0; c < NCH; c++)
          if (SH[c]) begin m_sa[c] = m_ss[c]; m_ca[c] = m_cs[c]; end
      end
      m_pend = (m_pend && !eop) || (we && addr == 6'h03 && wdata[0]);
      if (we) begin
        if (addr == 6'h00) begin
          if (PER_SH) m_per_s = wdata; else m_per = wdata;
        end
        if (addr == 6'h01) for (int c = 0; c < NCH && c < 8; c++) m_en[c] = wdata[c];
        if (addr == 6'h02) for (int c = 8; c < NCH; c++) m_en[c] = wdata[c-8];
        for (int c = 0; c < NCH; c++) begin
          if (addr == 6'(16 + 2*c)) begin
            if (SH[c]) m_ss[c] = wdata; else m_sa[c] = wdata;
          end
          if (addr == 6'(17 + 2*c)) begin
            if (SH[c]) m_cs[c] = wdata; else m_ca[c] = wdata;
          end
        end
      end
      m_cnt = eop ? 8'd0 : m_cnt + 8'd1;
      m_out = m_nx;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp && !done) begin
      n_chk++;
      if (pwm !== m_out) begin
        n_fail++;
        $display("FAIL R3 waveform act=%b exp=%b t=%0t", pwm, m_out, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 6'h3f; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(rdata === exp, tag, int'(rdata), int'(exp));
  endtask

  task automatic wait_commit(input string tag);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); addr = 6'h03; #1;
      if (rdata == 8'd0) break;
    end
    chk(rdata === 8'd0, tag, int'(rdata), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pwm === '0, "R1 outputs in reset", int'(pwm), 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    rd(6'h00, 8'hff, "R1 period reset");
    rd(6'h03, 8'h00, "R1 sync reset");
    rd(6'h10, 8'h00, "R1 edge reset");
    rd(6'h01, 8'h00, "R1 enable reset");

    // staged period and staged channel 1
    wr(6'h00, 8'd9);
    rd(6'h00, 8'hff, "R6 period held");
    wr(6'h12, 8'd4);
    wr(6'h13, 8'd8);
    rd(6'h12, 8'h00, "R6 staged set hidden");
    // direct channel 0
    wr(6'h10, 8'd2);
    rd(6'h10, 8'd2, "R5 direct set visible");
    wr(6'h11, 8'd7);
    wr(6'h01, 8'hff);
    wr(6'h02, 8'h03);
    rd(6'h01, 8'hff, "R4 enable low");
    rd(6'h02, 8'h03, "R4 enable high");
    idle(4);
    chk(pwm[1] === 1'b0, "R6 staged channel idle", int'(pwm[1]), 0);

    wr(6'h03, 8'h00);
    rd(6'h03, 8'h00, "R9 sync zero ignored");
    rd(6'h12, 8'h00, "R9 no commit");

    wr(6'h03, 8'h01);
    rd(6'h03, 8'h01, "R7 sync pending");
    wait_commit("R8 sync self clear");
    rd(6'h00, 8'd9, "R7 period committed");
    rd(6'h12, 8'd4, "R7 set committed");
    rd(6'h13, 8'd8, "R7 clear committed");

    // varied edge patterns
    wr(6'h14, 8'd5); wr(6'h15, 8'd5);   // ch2 equal edges
    wr(6'h18, 8'd7); wr(6'h19, 8'd2);   // ch4 across wrap
    wr(6'h1a, 8'd0); wr(6'h1b, 8'd9);   // ch5
    wr(6'h20, 8'd3); wr(6'h21, 8'd4);   // ch8
    wr(6'h16, 8'd1); wr(6'h17, 8'd6);   // ch3 staged
    wr(6'h22, 8'd8); wr(6'h23, 8'd1);   // ch9 staged
    wr(6'h03, 8'h01);
    wait_commit("R7 second commit");
    idle(40);
    chk(pwm[2] === 1'b0, "R3 equal edges low", int'(pwm[2]), 0);

    // late write after commit
    wr(6'h03, 8'h01);
    wait_commit("R8 third commit");
    wr(6'h12, 8'd0);
    idle(30);
    rd(6'h12, 8'd4, "R8 late write not applied");

    // disable channel 0
    wr(6'h01, 8'hfe);
    idle(3);
    chk(pwm[0] === 1'b0, "R4 disabled low", int'(pwm[0]), 0);
    idle(22);
    wr(6'h01, 8'hff);

    // sweep small periods and all edge pairs
    for (int p = 0; p <= 4; p++) begin
      wr(6'h00, 8'(p));
      wr(6'h03, 8'h01);
      wait_commit("R7 period sweep commit");
      rd(6'h00, 8'(p), "R2 period sweep readback");
      for (int s = 0; s <= p; s++) begin
        for (int e = 0; e <= p; e++) begin
          wr(6'h10, 8'(s)); wr(6'h11, 8'(e));
          wr(6'h12, 8'(e)); wr(6'h13, 8'(s));
          wr(6'h03, 8'h01);
          wait_commit("R7 edge sweep commit");
          idle(2 * (p + 1) + 2);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule